// File: doc/BRIEF.md
# Protected Runtime Clock Prescaler

This block divides the master clock by a power of two that software selects at run time. It issues a one-cycle clock enable for the core and the synchronous peripherals. Software reaches it through one 8-bit control register on a simple write/read bus. The bus has a write strobe, an address-match qualifier, write data and read data that is always driven.

The division select is protected by a timed unlock. A write of exactly 0x80 arms a change-enable flag for four master cycles. Only a write made while the flag is set can load a new select value. While the flag is set, the block raises a request for the interrupt logic to hold off interrupts.

A new factor is applied only at the end of the current divided period, so the enable never shows a short period. A static configuration input can route the divided clock level onto a port pin in place of that pin's normal output. This routing also applies while reset is held.

Top module: `clk_prescaler`

## Requirements
- R1: The read data is {change-enable at bit 7, zeros at bits 6..4, select at bits 3..0}. After reset the whole register reads 0x00.
- R2: A qualified write of exactly 0x80 while the flag is clear sets the change-enable flag. A write with bit 7 set and any other bit set leaves both the flag and the select unchanged.
- R3: A qualified write with bit 7 clear loads bits 3..0 into the select and clears the flag in the same cycle, provided the flag is set. If the flag is clear, such a write leaves the select unchanged.
- R4: Once set, the flag stays high for exactly four master cycles unless a select write clears it earlier. A select write in the fourth cycle is accepted; one in the fifth is ignored.
- R5: The interrupt hold-off output is high exactly while the change-enable flag is set.
- R6: Select values 0..8 give a div_en pulse of one master cycle every 2^select cycles. Values 9..15 give div_en in every cycle.
- R7: A changed select takes effect only after the div_en pulse that ends the current period. Every gap between pulses equals the old factor or the new factor.
- R8: When clkout_cfg is 1, pin_out shows the divided clock: the master clock itself for a factor of 1, otherwise high for the first half of each period. This also holds during reset. When clkout_cfg is 0, pin_out follows gpio_out.
- R9: A write without addr_hit changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| addr_hit | input | 1 | address matches the control register |
| wdata | input | 8 | write data |
| rdata | output | 8 | register read data |
| clkout_cfg | input | 1 | static: route divided clock to pin |
| gpio_out | input | 1 | normal port output for the pin |
| pin_out | output | 1 | pin drive |
| div_en | output | 1 | divided clock enable |
| irq_hold | output | 1 | request to hold off interrupts |

## Verification
The hardest situation to reach from the ports is a select write that lands exactly on the last cycle of the four-cycle window, or just after it. The same applies to a select change made near the end of a long divided period. Directed sequences place a write on the fourth and fifth cycle after arming. The random phase arms the window and then issues select writes after a random delay of zero to six cycles. A cycle-accurate bench model tracks every pulse gap across factor changes.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 8,
  parameter int WIN_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr_hit,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       clkout_cfg,
  input  logic       gpio_out,
  output logic       pin_out,
  output logic       div_en,
  output logic       irq_hold
);
  localparam int CNT_W = MAX_SEL;
  localparam int WC_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WC_W-1:0] WC_LOAD = WC_W'(WIN_CYC - 1);

  logic             ce;
  logic [WC_W-1:0]  wcnt;
  logic [SEL_W-1:0] sel, act;
  logic [CNT_W-1:0] cnt, last_cnt, half;
  logic             wr, arm_req, sel_req, div_lvl;

  function automatic logic [CNT_W-1:0] period_m1(input logic [SEL_W-1:0] s);
    logic [CNT_W:0] n;
    n = (int'(s) > MAX_SEL) ? (CNT_W+1)'(1) : ((CNT_W+1)'(1) << s);
    return CNT_W'(n - 1'b1);
  endfunction

  assign wr      = wr_en & addr_hit;
  assign arm_req = wr && (wdata == 8'h80);
  assign sel_req = wr && !wdata[7] && ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce   <= 1'b0;
      wcnt <= '0;
      sel  <= '0;
    end else if (sel_req) begin
      sel <= wdata[SEL_W-1:0];
      ce  <= 1'b0;
    end else if (arm_req && !ce) begin
      ce   <= 1'b1;
      wcnt <= WC_LOAD;
    end else if (ce) begin
      if (wcnt == '0) ce <= 1'b0;
      else            wcnt <= wcnt - 1'b1;
    end
  end

  assign last_cnt = period_m1(act);
  assign div_en   = (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= '0;
    end else if (div_en) begin
      cnt <= '0;
      act <= sel;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign half    = CNT_W'(({1'b0, last_cnt} + 1'b1) >> 1);
  assign div_lvl = (last_cnt == '0) ? clk : (cnt < half);
  assign pin_out = clkout_cfg ? div_lvl : gpio_out;

  assign irq_hold = ce;
  assign rdata    = {ce, 3'b000, {(4-SEL_W){1'b0}}, sel};
endmodule

// File: rtl/clk_prescaler_chk.sv
module clk_prescaler_chk #(
  parameter int WIN_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr_hit,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_hold
);
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)        run <= '0;
    else if (rdata[7]) run <= (run == 8'hFF) ? run : run + 1'b1;
    else               run <= '0;
  end

  // R2
  bad_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hit && wdata[7] && wdata[6:0] != 7'd0 && !irq_hold) |=> !irq_hold);

  // R3
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_hit && !wdata[7] && irq_hold) |=> (!irq_hold && rdata[3:0] == $past(wdata[3:0])));

  // R4
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 8'(WIN_CYC));

  // R9
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr_hit) |=> $stable(rdata[3:0]));
endmodule

bind clk_prescaler clk_prescaler_chk #(.WIN_CYC(WIN_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
  .wdata(wdata), .rdata(rdata), .irq_hold(irq_hold)
);

// File: tb/clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module clk_prescaler_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr_hit = 1'b0, clkout_cfg = 1'b1, gpio_out = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pin_out, div_en, irq_hold;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
    .wdata(wdata), .rdata(rdata), .clkout_cfg(clkout_cfg),
    .gpio_out(gpio_out), .pin_out(pin_out), .div_en(div_en),
    .irq_hold(irq_hold)
  );

  // bench model, built from the requirements
  bit m_ce; int m_win; int m_sel, m_act, m_cnt;

  function automatic int factor(input int s);
    return (s > 8) ? 1 : (1 << s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ce <= 0; m_win <= 0; m_sel <= 0; m_act <= 0; m_cnt <= 0;
    end else begin
      if (wr_en && addr_hit && !wdata[7] && m_ce) begin
        m_sel <= wdata[3:0]; m_ce <= 0;
      end else if (wr_en && addr_hit && wdata == 8'h80 && !m_ce) begin
        m_ce <= 1; m_win <= 1;
      end else if (m_ce) begin
        if (m_win == 4) m_ce <= 0;
        else m_win <= m_win + 1;
      end
      if (m_cnt == factor(m_act) - 1) begin
        m_cnt <= 0; m_act <= m_sel;
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int n;
    n = factor(m_act);
    chk("R1 R3 rdata", rdata, {m_ce, 3'b000, 4'(m_sel)});
    chk("R5 irq_hold", irq_hold, m_ce);
    chk("R6 R7 div_en", div_en, (m_cnt == n - 1));
    if (clkout_cfg) chk("R8 pin", pin_out, (n == 1) ? 0 : (m_cnt < n / 2));
    else            chk("R8 pin gpio", pin_out, gpio_out);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) cmp_all();
  endtask

  task automatic wr(input logic [7:0] d, input logic hit);
    wr_en = 1; addr_hit = hit; wdata = d;
    tick();
    wr_en = 0; addr_hit = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    // R8: clock routed to pin during reset, factor 1
    repeat (3) @(negedge clk);
    chk("R8 reset low", pin_out, 0);
    @(posedge clk); #1;
    chk("R8 reset high", pin_out, 1);
    @(negedge clk);
    chk("R1 reset value", rdata, 8'h00);
    rst_n = 1;
    tick();
    // R3: select write without arming ignored
    wr(8'h03, 1); chk("R3 unarmed", rdata, 8'h00);
    // R2: bad arm pattern
    wr(8'h81, 1); chk("R2 bad arm", irq_hold, 0);
    // R9: arm without address match
    wr(8'h80, 0); chk("R9 no hit", irq_hold, 0);
    // R4: accepted on fourth cycle
    wr(8'h80, 1);
    for (int i = 0; i < 3; i++) begin chk("R4 open", irq_hold, 1); tick(); end
    chk("R4 open4", irq_hold, 1);
    wr(8'h02, 1); chk("R4 R3 fourth", rdata, 8'h02);
    // R4: rejected on fifth cycle
    wr(8'h80, 1);
    repeat (4) tick();
    chk("R4 closed", irq_hold, 0);
    wr(8'h05, 1); chk("R4 fifth", rdata, 8'h02);
    // R6: reserved select, and largest factor
    wr(8'h80, 1); wr(8'h0C, 1);
    repeat (10) tick();
    chk("R6 reserved div_en", div_en, 1);
    wr(8'h80, 1); wr(8'h08, 1);
    repeat (600) tick();
    // random phase
    for (int c = 0; c < 20000; c++) begin
      int op;
      op = $urandom_range(0, 99);
      if ($urandom_range(0, 499) == 0) clkout_cfg = ~clkout_cfg;
      gpio_out = $urandom_range(0, 1);
      if (op < 6) begin
        wr(8'h80, 1);
        repeat ($urandom_range(0, 6)) tick();
        wr({1'b0, 3'($urandom), 4'($urandom_range(0, 9))}, $urandom_range(0, 7) != 0);
      end else if (op < 9) begin
        wr(8'($urandom), $urandom_range(0, 1));
      end else begin
        tick();
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule